// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit decides which interrupt a 16550-style serial controller reports to the host, and when. There are five event sources: receive line error, received data at or above the trigger level, character timeout, transmit holding register emptied, and modem input change. The receive-data and timeout sources share one group. Each source is gated by a four-bit enable register. The enabled sources are ranked in a fixed order. The winner is encoded into an identification byte that the host reads at offset 2. A write to the same offset programs the FIFO control: enable, flush requests and receive trigger depth.

Each source is cleared by its own host access. A line error clears on a line-status read at offset 5. A modem change clears on a modem-status read at offset 6. A timeout clears on a receive-buffer read at offset 0. Transmit-empty clears on a holding-register write at offset 0, or on an identification read that reports transmit-empty. Received data stops being reported once the FIFO level drops below the threshold. The shift registers, FIFO storage and baud timing are outside this unit. Their status arrives on input strobes and levels. The request line is qualified by a gate level that comes from the modem control register.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the enable register reads 0x00 at offset 1, the identification byte reads 0x01 at offset 2, `fifo_on` is 0 and `irq` is 0.
- R2: The enable register is written and read at offset 1. Bit0 enables receive data and timeout, bit1 transmit empty, bit2 line error, bit3 modem change. Bits 7:4 read as 0.
- R3: Among enabled pending sources, the ranking is line error (code 0x06), then receive data (0x04), then timeout (0x0C), then transmit empty (0x02), then modem change (0x00). Only the highest-ranked code is shown, in identification bits 3:0.
- R4: Identification bit0 is 1 when nothing enabled is pending. `irq` is high exactly when bit0 is 0 and `irq_gate` is 1.
- R5: Identification bits 7:6 read 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R6: A `line_err` pulse makes the line-error source pending. A host read at offset 5 clears it.
- R7: Receive data is pending when `rx_level` is nonzero with FIFOs off. With FIFOs on, it is pending when `rx_level` is at least the trigger depth. The depth comes from control bits 7:6: 00=1, 01=4, 10=8, 11=14. It stops being pending once the level falls below that depth.
- R8: A `rx_timeout` pulse makes the timeout source pending. A host read at offset 0 clears it.
- R9: Transmit-empty becomes pending on a rising edge of `thr_empty`, or when enable bit1 goes from 0 to 1 while `thr_empty` is 1. It is cleared by a host write at offset 0, or by a read at offset 2 that returns code 0x02.
- R10: A `modem_delta` pulse makes the modem source pending. A host read at offset 6 clears it.
- R11: A write at offset 2 programs the FIFO control. Bit0 becomes `fifo_on`. When bit0 is 1, bits 7:6 set the trigger depth, bit1 requests a receive flush and bit2 requests a transmit flush. A change of bit0 requests both flushes. Flush requests appear as one-cycle pulses in the cycle after the write. When bit0 is 0 and unchanged, bits 1 and 2 have no effect.
- R12: A source whose enable is clear stays pending but is not reported. It is reported as soon as its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Host register offset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (applies read side effects) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for offsets 1 and 2, otherwise 0 |
| line_err | input | 1 | Receive line error event pulse |
| rx_timeout | input | 1 | Character timeout event pulse |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_delta | input | 1 | Modem input change event pulse |
| irq_gate | input | 1 | Output gate from modem control |
| irq | output | 1 | Interrupt request |
| fifo_on | output | 1 | FIFOs enabled |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
The assertions assume that event pulses and host strobes are synchronous single-cycle signals. They also assume that read and write are never asserted together. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It never overlaps a read with a write. It also keeps `rx_level` within the FIFO depth, so the flag, encoder and flush properties see only legal traffic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned NSRC = 5;
   localparam int unsigned S_LINE  = 0;
   localparam int unsigned S_RXD   = 1;
   localparam int unsigned S_TMO   = 2;
   localparam int unsigned S_THRE  = 3;
   localparam int unsigned S_MODEM = 4;

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_IEN  = 3'd1;
   localparam logic [2:0] A_IID  = 3'd2;
   localparam logic [2:0] A_LSTS = 3'd5;
   localparam logic [2:0] A_MSTS = 3'd6;

   typedef enum logic [3:0] {
      ID_LINE  = 4'h6,
      ID_RXD   = 4'h4,
      ID_TMO   = 4'hC,
      ID_THRE  = 4'h2,
      ID_MODEM = 4'h0,
      ID_NONE  = 4'h1
   } iid_e;

   function automatic iid_e src_code(input int unsigned idx);
      case (idx)
         S_LINE:  return ID_LINE;
         S_RXD:   return ID_RXD;
         S_TMO:   return ID_TMO;
         S_THRE:  return ID_THRE;
         default: return ID_MODEM;
      endcase
   endfunction

   function automatic int unsigned trig_bytes(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/src_flag.sv
module src_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);

   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);
   // R9
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pend);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
#(
   parameter int unsigned N = NSRC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] active,
   output logic [3:0]   code
);

   logic [N-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++)
         if (active[i] && sel == '0) sel[i] = 1'b1;
   end

   always_comb begin
      code = ID_NONE;
      for (int i = 0; i < N; i++)
         if (sel[i]) code = src_code(i);
   end

   // R3
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R3
   top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active[0] |-> (code == ID_LINE));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter  int unsigned FIFO_DEPTH    = 16,
   parameter  bit          THRE_ON_ENABLE = 1'b1,
   localparam int unsigned LVL_W          = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             line_err,
   input  logic             rx_timeout,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             thr_empty,
   input  logic             modem_delta,
   input  logic             irq_gate,
   output logic             irq,
   output logic             fifo_on,
   output logic             rx_flush,
   output logic             tx_flush
);

   if (FIFO_DEPTH < 14) begin : g_depth_bad
      $error("FIFO_DEPTH must cover the largest trigger depth of 14");
   end

   logic [3:0]      ien;
   logic [1:0]      trig_sel;
   logic            thr_empty_q;
   logic [NSRC-1:0] pend, active;
   logic [3:0]      code;
   logic [7:0]      iid_byte;
   logic            rxd_avail, thre_set, thre_clr;
   logic            wr_ien, wr_fcr, wr_data, rd_data, rd_iid, rd_lsts, rd_msts;
   logic            unused_bits;

   assign unused_bits = ^reg_wdata[5:3];

   assign wr_ien  = reg_wr && reg_addr == A_IEN;
   assign wr_fcr  = reg_wr && reg_addr == A_IID;
   assign wr_data = reg_wr && reg_addr == A_DATA;
   assign rd_data = reg_rd && reg_addr == A_DATA;
   assign rd_iid  = reg_rd && reg_addr == A_IID;
   assign rd_lsts = reg_rd && reg_addr == A_LSTS;
   assign rd_msts = reg_rd && reg_addr == A_MSTS;

   // enable and FIFO control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien         <= '0;
         fifo_on     <= 1'b0;
         trig_sel    <= 2'b00;
         rx_flush    <= 1'b0;
         tx_flush    <= 1'b0;
         thr_empty_q <= 1'b0;
      end else begin
         thr_empty_q <= thr_empty;
         rx_flush    <= 1'b0;
         tx_flush    <= 1'b0;
         if (wr_ien) ien <= reg_wdata[3:0];
         if (wr_fcr) begin
            fifo_on  <= reg_wdata[0];
            rx_flush <= (reg_wdata[0] != fifo_on) || (reg_wdata[0] && reg_wdata[1]);
            tx_flush <= (reg_wdata[0] != fifo_on) || (reg_wdata[0] && reg_wdata[2]);
            if (reg_wdata[0]) trig_sel <= reg_wdata[7:6];
         end
      end
   end

   // transmit-empty set condition, variant chosen by parameter
   if (THRE_ON_ENABLE) begin : g_thre_en
      assign thre_set = (thr_empty && !thr_empty_q)
                     || (wr_ien && reg_wdata[1] && !ien[1] && thr_empty);
   end else begin : g_thre_edge
      assign thre_set = thr_empty && !thr_empty_q;
   end
   assign thre_clr = wr_data || (rd_iid && code == ID_THRE);

   src_flag u_line  (.clk(clk), .rst_n(rst_n), .set(line_err),    .clr(rd_lsts),  .pend(pend[S_LINE]));
   src_flag u_tmo   (.clk(clk), .rst_n(rst_n), .set(rx_timeout),  .clr(rd_data),  .pend(pend[S_TMO]));
   src_flag u_thre  (.clk(clk), .rst_n(rst_n), .set(thre_set),    .clr(thre_clr), .pend(pend[S_THRE]));
   src_flag u_modem (.clk(clk), .rst_n(rst_n), .set(modem_delta), .clr(rd_msts),  .pend(pend[S_MODEM]));

   assign rxd_avail   = fifo_on ? (rx_level >= LVL_W'(trig_bytes(trig_sel)))
                                : (rx_level != '0);
   assign pend[S_RXD] = rxd_avail;

   assign active[S_LINE]  = pend[S_LINE]  && ien[2];
   assign active[S_RXD]   = pend[S_RXD]   && ien[0];
   assign active[S_TMO]   = pend[S_TMO]   && ien[0];
   assign active[S_THRE]  = pend[S_THRE]  && ien[1];
   assign active[S_MODEM] = pend[S_MODEM] && ien[3];

   irq_prio_enc #(.N(NSRC)) u_enc (
      .clk(clk), .rst_n(rst_n), .active(active), .code(code)
   );

   assign iid_byte = {{2{fifo_on}}, 2'b00, code};
   assign irq      = irq_gate && !code[0];

   always_comb begin
      case (reg_addr)
         A_IEN:   reg_rdata = {4'b0000, ien};
         A_IID:   reg_rdata = iid_byte;
         default: reg_rdata = 8'h00;
      endcase
   end

   // R11
   flush_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flush || tx_flush) |-> $past(wr_fcr));
   // R11
   enable_toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on != $past(fifo_on)) |-> (rx_flush && tx_flush));
   // R4
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_gate && active != '0));

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

   localparam int LVL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic             reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]       reg_wdata = '0;
   logic [7:0]       reg_rdata;
   logic             line_err = 1'b0, rx_timeout = 1'b0, modem_delta = 1'b0;
   logic [LVL_W-1:0] rx_level = '0;
   logic             thr_empty = 1'b1, irq_gate = 1'b1;
   logic             irq, fifo_on, rx_flush, tx_flush;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   uart_irq_ident u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_err(line_err),
      .rx_timeout(rx_timeout), .rx_level(rx_level), .thr_empty(thr_empty),
      .modem_delta(modem_delta), .irq_gate(irq_gate), .irq(irq), .fifo_on(fifo_on),
      .rx_flush(rx_flush), .tx_flush(tx_flush)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: line_err = 1'b1;
         1: rx_timeout = 1'b1;
         default: modem_delta = 1'b1;
      endcase
      @(negedge clk);
      line_err = 1'b0; rx_timeout = 1'b0; modem_delta = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      peek(3'd2, v); chk("R1 iid", v, 8'h01);
      peek(3'd1, v); chk("R1 ien", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 fifo_on", {7'd0, fifo_on}, 8'h00);
   endtask

   task automatic t_ien;
      logic [7:0] v;
      wr(3'd1, 8'hFF);
      peek(3'd1, v); chk("R2 readback", v, 8'h0F);
      wr(3'd1, 8'h00);
   endtask

   task automatic t_thre;
      logic [7:0] v;
      wr(3'd1, 8'h02);
      peek(3'd2, v); chk("R9 enable while empty", v, 8'h02);
      irq_gate = 1'b1; #1 chk("R4 irq gated on", {7'd0, irq}, 8'h01);
      irq_gate = 1'b0; #1 chk("R4 irq gated off", {7'd0, irq}, 8'h00);
      irq_gate = 1'b1;
      rd(3'd2, v); chk("R9 iid read value", v, 8'h02);
      peek(3'd2, v); chk("R9 cleared by iid read", v, 8'h01);
      @(negedge clk); thr_empty = 1'b0;
      @(negedge clk); thr_empty = 1'b1;
      @(negedge clk);
      peek(3'd2, v); chk("R9 rising edge", v, 8'h02);
      wr(3'd0, 8'h55);
      peek(3'd2, v); chk("R9 cleared by holding write", v, 8'h01);
      chk("R4 no irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_modem;
      logic [7:0] v;
      wr(3'd1, 8'h08);
      pulse(2);
      peek(3'd2, v); chk("R10 modem code", v, 8'h00);
      rd(3'd6, v);
      peek(3'd2, v); chk("R10 cleared by status read", v, 8'h01);
   endtask

   task automatic t_mask;
      logic [7:0] v;
      wr(3'd1, 8'h00);
      pulse(0);
      peek(3'd2, v); chk("R12 masked not shown", v, 8'h01);
      chk("R12 masked no irq", {7'd0, irq}, 8'h00);
      wr(3'd1, 8'h04);
      peek(3'd2, v); chk("R12 revealed on enable", v, 8'h06);
      rd(3'd5, v);
      peek(3'd2, v); chk("R6 cleared by line read", v, 8'h01);
   endtask

   task automatic t_prio;
      logic [7:0] v;
      wr(3'd1, 8'h0F);
      @(negedge clk); thr_empty = 1'b0;
      @(negedge clk); thr_empty = 1'b1;
      pulse(2);
      pulse(1);
      pulse(0);
      rx_level = 5'd1;
      @(negedge clk);
      peek(3'd2, v); chk("R3 line highest", v, 8'h06);
      rd(3'd5, v);
      peek(3'd2, v); chk("R3 receive data next", v, 8'h04);
      rx_level = 5'd0; #1
      peek(3'd2, v); chk("R3 timeout next", v, 8'h0C);
      rd(3'd0, v);
      peek(3'd2, v); chk("R8 timeout cleared, transmit next", v, 8'h02);
      rd(3'd2, v);
      peek(3'd2, v); chk("R3 modem last", v, 8'h00);
      rd(3'd6, v);
      peek(3'd2, v); chk("R3 all clear", v, 8'h01);
   endtask

   task automatic t_fifo;
      logic [7:0] v;
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h01);
      chk("R11 enable flush", {6'd0, rx_flush, tx_flush}, 8'h03);
      chk("R11 fifo_on", {7'd0, fifo_on}, 8'h01);
      @(negedge clk);
      chk("R11 flush one cycle", {6'd0, rx_flush, tx_flush}, 8'h00);
      peek(3'd2, v); chk("R5 fifo flag bits", v, 8'hC1);
      wr(3'd2, 8'h41);
      chk("R11 no flush", {6'd0, rx_flush, tx_flush}, 8'h00);
      wr(3'd1, 8'h01);
      rx_level = 5'd3; #1
      peek(3'd2, v); chk("R7 below trigger 4", v, 8'hC1);
      rx_level = 5'd4; #1
      peek(3'd2, v); chk("R7 at trigger 4", v, 8'hC4);
      wr(3'd2, 8'hC3);
      chk("R11 rx flush only", {6'd0, rx_flush, tx_flush}, 8'h02);
      peek(3'd2, v); chk("R7 below trigger 14", v, 8'hC1);
      rx_level = 5'd14; #1
      peek(3'd2, v); chk("R7 at trigger 14", v, 8'hC4);
      wr(3'd2, 8'h06);
      chk("R11 disable flush", {6'd0, rx_flush, tx_flush}, 8'h03);
      peek(3'd2, v); chk("R5 flags off", v, 8'h04);
      wr(3'd2, 8'h06);
      chk("R11 flush bits ignored when off", {6'd0, rx_flush, tx_flush}, 8'h00);
      rx_level = 5'd0; #1
      peek(3'd2, v); chk("R7 empty", v, 8'h01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ien;
      t_thre;
      t_modem;
      t_mask;
      t_prio;
      t_fifo;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule